// File: doc/BRIEF.md
# USB Host Interrupt Flag Controller

This block keeps the interrupt status of a USB host controller. The protocol logic around it sends single-cycle pulses for these events: device attach, device removal, a RAM access failure during an OUT stage, resume signalling from the device, resume signalling sent downstream, and a bus reset sent to the device. Each pulse latches a sticky flag. A built-in frame timer supplies the start-of-frame event, and a frame number advances with it.

A wake-up flag is derived from the controller state at the moment an event arrives. It sets on a device resume or a removal while frame generation is off (suspend). It also sets on an attach while the bus supply is reported good.

Software clears flags by writing ones on a write port. A separate enable mask selects which flags may raise the single registered interrupt line.

Top module: `usbh_irq_flags`

## Requirements
- R1: While and right after reset, `flags` is 0x0000, `irq` is 0 and `frame_num` is 0.
- R2: An event pulse sets its flag at the next clock edge, where it stays until cleared. The flag positions are: removal bit 9, attach bit 8, RAM error bit 7, device resume bit 6, downstream resume bit 5, wake-up bit 4, bus reset bit 3, start-of-frame bit 2.
- R3: A write with `wr_en` high clears every flag whose `wr_data` bit is one. Flags whose `wr_data` bit is zero keep their value.
- R4: When an event and a write-one clear hit the same flag in the same cycle, the flag ends up set.
- R5: Bits 15:10, 1 and 0 of `flags` always read zero, and writes to them have no effect.
- R6: `irq` is high one cycle after any flag is set while its `ien` bit is one. It is low one cycle after no enabled flag is set.
- R7: The wake-up flag (bit 4) sets on a device resume pulse while `sof_en` is low.
- R8: The wake-up flag sets on a removal pulse while `sof_en` is low.
- R9: The wake-up flag sets on an attach pulse while `vbus_ok` is high. An attach with `vbus_ok` low leaves it clear.
- R10: While `sof_en` is high, the start-of-frame flag sets and `frame_num` increments once every `TICKS_PER_FRAME` cycles, wrapping from 2047 to 0. While `sof_en` is low the timer is held and `frame_num` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof_en | input | 1 | Frame generation on (low means suspend) |
| vbus_ok | input | 1 | Bus supply good (operational) |
| ev_ddisc | input | 1 | Device removal pulse |
| ev_dconn | input | 1 | Device attach pulse |
| ev_ramerr | input | 1 | RAM access error pulse |
| ev_uprsm | input | 1 | Resume from device pulse |
| ev_dnrsm | input | 1 | Downstream resume sent pulse |
| ev_busrst | input | 1 | Bus reset sent pulse |
| wr_en | input | 1 | Write strobe for the clear port |
| wr_data | input | 16 | Write-one-to-clear data |
| ien | input | 16 | Interrupt enable mask |
| flags | output | 16 | Flag register |
| irq | output | 1 | Registered interrupt request |
| frame_num | output | 11 | Frame number |

## Verification
The bench builds the block with `TICKS_PER_FRAME` set to 5 and keeps the 11-bit frame number. A frame therefore lasts five cycles. Both the first start-of-frame flag and the full 2048-frame wrap of the frame number can be reached in about ten thousand cycles. The same short frame lets the set and clear scenarios run with the timer stopped, so the start-of-frame flag never disturbs their expected values.

// File: rtl/usbh_irq_pkg.sv
package usbh_irq_pkg;

  localparam int FLAG_W   = 16;
  localparam int B_SOF    = 2;
  localparam int B_BUSRST = 3;
  localparam int B_WAKE   = 4;
  localparam int B_DNRSM  = 5;
  localparam int B_UPRSM  = 6;
  localparam int B_RAMERR = 7;
  localparam int B_DCONN  = 8;
  localparam int B_DDISC  = 9;

  localparam logic [FLAG_W-1:0] IMPL_MASK =
    (FLAG_W'(1) << B_SOF)   | (FLAG_W'(1) << B_BUSRST) |
    (FLAG_W'(1) << B_WAKE)  | (FLAG_W'(1) << B_DNRSM)  |
    (FLAG_W'(1) << B_UPRSM) | (FLAG_W'(1) << B_RAMERR) |
    (FLAG_W'(1) << B_DCONN) | (FLAG_W'(1) << B_DDISC);

  typedef struct packed {
    logic ddisc;
    logic dconn;
    logic ramerr;
    logic uprsm;
    logic dnrsm;
    logic busrst;
    logic sof;
  } host_evt_t;

  // Wake-up: resume or removal while suspended, attach while operational
  function automatic logic wake_cond(input logic sof_en, input logic vbus_ok,
                                     input logic uprsm, input logic ddisc,
                                     input logic dconn);
    return (!sof_en && (uprsm || ddisc)) || (vbus_ok && dconn);
  endfunction

  function automatic logic [FLAG_W-1:0] evt_to_vec(input host_evt_t e,
                                                   input logic wake);
    logic [FLAG_W-1:0] v;
    v = '0;
    v[B_DDISC]  = e.ddisc;
    v[B_DCONN]  = e.dconn;
    v[B_RAMERR] = e.ramerr;
    v[B_UPRSM]  = e.uprsm;
    v[B_DNRSM]  = e.dnrsm;
    v[B_WAKE]   = wake;
    v[B_BUSRST] = e.busrst;
    v[B_SOF]    = e.sof;
    return v;
  endfunction

  // Clear first, then set: a same-cycle event wins
  function automatic logic [FLAG_W-1:0] next_flags(input logic [FLAG_W-1:0] cur,
                                                   input logic [FLAG_W-1:0] set,
                                                   input logic [FLAG_W-1:0] clr);
    return ((cur & ~clr) | set) & IMPL_MASK;
  endfunction

endpackage

// File: rtl/usbh_frame_timer.sv
module usbh_frame_timer #(
  parameter int TICKS_PER_FRAME = 48000,
  parameter int FNUM_W          = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sof_en,
  output logic              sof_pulse,
  output logic [FNUM_W-1:0] frame_num
);
  localparam int CNT_W = (TICKS_PER_FRAME > 2) ? $clog2(TICKS_PER_FRAME) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_FRAME - 1);

  logic [CNT_W-1:0] cnt_q;

  assign sof_pulse = sof_en && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      frame_num <= '0;
    end else if (!sof_en) begin
      cnt_q <= '0;
    end else if (sof_pulse) begin
      cnt_q     <= '0;
      frame_num <= frame_num + 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  a_r10_frame_step: assert property (@(posedge clk) disable iff (!rst_n)
    sof_pulse |=> frame_num == FNUM_W'($past(frame_num) + 1'b1));
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sof_en |=> $stable(frame_num));
endmodule

// File: rtl/usbh_flag_bank.sv
module usbh_flag_bank
  import usbh_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_W-1:0] set_vec,
  input  logic              wr_en,
  input  logic [FLAG_W-1:0] wr_data,
  output logic [FLAG_W-1:0] flags
);
  logic [FLAG_W-1:0] clr_vec;

  assign clr_vec = wr_en ? wr_data : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= next_flags(flags, set_vec, clr_vec);
  end

  a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec != '0) |=> ((flags & $past(clr_vec & ~set_vec)) == '0));
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & $past(flags & ~clr_vec)) == $past(flags & ~clr_vec)));
  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((flags & $past(set_vec & IMPL_MASK)) == $past(set_vec & IMPL_MASK)));
  a_r5_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (flags & ~IMPL_MASK) == '0);
endmodule

// File: rtl/usbh_irq_gen.sv
module usbh_irq_gen #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] flags,
  input  logic [W-1:0] ien,
  output logic         irq
);
  logic hit;

  assign hit = |(flags & ien);

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= hit;
  end

  a_r6_masked_low: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & ien) == '0) |=> !irq);
  a_r6_enabled_high: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & ien) != '0) |=> irq);
endmodule

// File: rtl/usbh_irq_flags.sv
module usbh_irq_flags
  import usbh_irq_pkg::*;
#(
  parameter int TICKS_PER_FRAME = 48000,
  parameter int FNUM_W          = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sof_en,
  input  logic              vbus_ok,
  input  logic              ev_ddisc,
  input  logic              ev_dconn,
  input  logic              ev_ramerr,
  input  logic              ev_uprsm,
  input  logic              ev_dnrsm,
  input  logic              ev_busrst,
  input  logic              wr_en,
  input  logic [FLAG_W-1:0] wr_data,
  input  logic [FLAG_W-1:0] ien,
  output logic [FLAG_W-1:0] flags,
  output logic              irq,
  output logic [FNUM_W-1:0] frame_num
);
  logic              sof_pulse;
  logic              wake_evt;
  host_evt_t         evt;
  logic [FLAG_W-1:0] set_vec;

  usbh_frame_timer #(
    .TICKS_PER_FRAME(TICKS_PER_FRAME),
    .FNUM_W(FNUM_W)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .sof_en(sof_en),
    .sof_pulse(sof_pulse), .frame_num(frame_num)
  );

  assign wake_evt = wake_cond(sof_en, vbus_ok, ev_uprsm, ev_ddisc, ev_dconn);

  always_comb begin
    evt.ddisc  = ev_ddisc;
    evt.dconn  = ev_dconn;
    evt.ramerr = ev_ramerr;
    evt.uprsm  = ev_uprsm;
    evt.dnrsm  = ev_dnrsm;
    evt.busrst = ev_busrst;
    evt.sof    = sof_pulse;
  end

  assign set_vec = evt_to_vec(evt, wake_evt);

  usbh_flag_bank u_bank (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec),
    .wr_en(wr_en), .wr_data(wr_data), .flags(flags)
  );

  usbh_irq_gen #(.W(FLAG_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .flags(flags), .ien(ien), .irq(irq)
  );

  a_r2_busrst_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ev_busrst |=> flags[B_BUSRST]);
  a_r2_sof_sets: assert property (@(posedge clk) disable iff (!rst_n)
    sof_pulse |=> flags[B_SOF]);
  a_r7_resume_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (!sof_en && ev_uprsm) |=> flags[B_WAKE]);
  a_r8_removal_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (!sof_en && ev_ddisc) |=> flags[B_WAKE]);
  a_r9_attach_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (vbus_ok && ev_dconn) |=> flags[B_WAKE]);
endmodule

// File: tb/test_usbh_irq_flags.sv
module test_usbh_irq_flags;
  localparam int CLK_PERIOD = 10;
  localparam int TICKS = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sof_en = 1'b0, vbus_ok = 1'b0;
  logic ev_ddisc = 0, ev_dconn = 0, ev_ramerr = 0, ev_uprsm = 0, ev_dnrsm = 0, ev_busrst = 0;
  logic wr_en = 1'b0;
  logic [15:0] wr_data = '0, ien = '0;
  logic [15:0] flags;
  logic irq;
  logic [10:0] frame_num;

  int checks = 0, fails = 0, cyc = 0;
  string phase = "R1";

  logic [15:0] m_flags = '0;
  logic m_irq = 1'b0;
  int m_cnt = 0, m_fn = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usbh_irq_flags #(.TICKS_PER_FRAME(TICKS), .FNUM_W(11)) i_usbh_irq_flags (
    .clk(clk), .rst_n(rst_n), .sof_en(sof_en), .vbus_ok(vbus_ok),
    .ev_ddisc(ev_ddisc), .ev_dconn(ev_dconn), .ev_ramerr(ev_ramerr),
    .ev_uprsm(ev_uprsm), .ev_dnrsm(ev_dnrsm), .ev_busrst(ev_busrst),
    .wr_en(wr_en), .wr_data(wr_data), .ien(ien),
    .flags(flags), .irq(irq), .frame_num(frame_num)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // Behavioural reference, updated on each rising edge
  always @(posedge clk) begin
    logic [15:0] setv, clrv;
    bit sofp;
    cyc++;
    if (!rst_n) begin
      m_flags = '0; m_irq = 0; m_cnt = 0; m_fn = 0;
    end else begin
      m_irq = ((m_flags & ien) != 0);
      sofp = 0;
      if (sof_en) begin
        if (m_cnt == TICKS - 1) begin
          sofp = 1; m_cnt = 0; m_fn = (m_fn + 1) % 2048;
        end else m_cnt++;
      end else m_cnt = 0;
      setv = 0;
      if (ev_ddisc)  setv |= 16'h0200;
      if (ev_dconn)  setv |= 16'h0100;
      if (ev_ramerr) setv |= 16'h0080;
      if (ev_uprsm)  setv |= 16'h0040;
      if (ev_dnrsm)  setv |= 16'h0020;
      if (ev_busrst) setv |= 16'h0008;
      if (sofp)      setv |= 16'h0004;
      if ((!sof_en && (ev_uprsm || ev_ddisc)) || (vbus_ok && ev_dconn)) setv |= 16'h0010;
      clrv = wr_en ? wr_data : 16'h0;
      for (int b = 0; b < 16; b++) begin
        if (setv[b]) m_flags[b] = 1'b1;
        else if (clrv[b]) m_flags[b] = 1'b0;
      end
      m_flags &= 16'h03FC;
    end
  end

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      check(flags === m_flags, {phase, " flags"}, flags, m_flags);
      check(irq === m_irq, {phase, " irq"}, irq, m_irq);
      check(frame_num === 11'(m_fn), {phase, " frame_num"}, frame_num, m_fn);
    end
    if (cyc > 100000) begin
      check(0, "watchdog", cyc, 100000);
      summary();
    end
  end

  // Pulse events (ddisc,dconn,ramerr,uprsm,dnrsm,busrst) with optional write
  task automatic drive(input logic [5:0] ev, input logic we, input logic [15:0] wd);
    @(negedge clk);
    {ev_ddisc, ev_dconn, ev_ramerr, ev_uprsm, ev_dnrsm, ev_busrst} = ev;
    wr_en = we; wr_data = wd;
    @(negedge clk);
    {ev_ddisc, ev_dconn, ev_ramerr, ev_uprsm, ev_dnrsm, ev_busrst} = '0;
    wr_en = 0; wr_data = '0;
  endtask

  task automatic clear_all();
    drive(6'b0, 1'b1, 16'hFFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(flags === 16'h0 && irq === 1'b0 && frame_num === 11'd0, "R1 reset", flags, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(flags === 16'h0 && irq === 1'b0, "R1 after reset", flags, 0);

    phase = "R2";
    drive(6'b000001, 0, 0); check(flags === 16'h0008, "R2 bus reset bit 3", flags, 16'h0008);
    drive(6'b000010, 0, 0); check(flags === 16'h0028, "R2 downstream resume bit 5", flags, 16'h0028);
    drive(6'b001000, 0, 0); check(flags === 16'h00A8, "R2 RAM error bit 7", flags, 16'h00A8);
    phase = "R3";
    clear_all(); check(flags === 16'h0, "R3 clear all", flags, 0);

    drive(6'b000011, 0, 0);
    drive(6'b0, 1, 16'h0008); check(flags === 16'h0020, "R3 clear one bit", flags, 16'h0020);
    drive(6'b0, 1, 16'h0000); check(flags === 16'h0020, "R3 zero write keeps", flags, 16'h0020);
    drive(6'b0, 1, 16'h0020); check(flags === 16'h0, "R3 last clear", flags, 0);

    phase = "R4";
    drive(6'b001000, 1, 16'h0080); check(flags === 16'h0080, "R4 set wins", flags, 16'h0080);
    clear_all();

    phase = "R5";
    drive(6'b000001, 1, 16'hFC03); check(flags === 16'h0008, "R5 reserved zero", flags, 16'h0008);
    clear_all();

    phase = "R6";
    drive(6'b000010, 0, 0);
    @(negedge clk); check(irq === 1'b0, "R6 masked", irq, 0);
    ien = 16'h0020;
    @(negedge clk); check(irq === 1'b1, "R6 enabled", irq, 1);
    ien = 16'hFFDF;
    @(negedge clk); check(irq === 1'b0, "R6 other bits", irq, 0);
    ien = 16'h0020;
    clear_all();
    @(negedge clk); check(irq === 1'b0, "R6 after clear", irq, 0);
    ien = '0;

    phase = "R7";
    drive(6'b000100, 0, 0); check(flags === 16'h0050, "R7 resume wakes", flags, 16'h0050);
    clear_all();
    phase = "R8";
    drive(6'b100000, 0, 0); check(flags === 16'h0210, "R8 removal wakes", flags, 16'h0210);
    clear_all();
    phase = "R9";
    vbus_ok = 1;
    drive(6'b010000, 0, 0); check(flags === 16'h0110, "R9 attach wakes", flags, 16'h0110);
    clear_all();
    vbus_ok = 0;
    drive(6'b010000, 0, 0); check(flags === 16'h0100, "R9 attach no vbus", flags, 16'h0100);
    clear_all();
    phase = "R7";
    @(negedge clk); sof_en = 1; ev_uprsm = 1;
    @(negedge clk); ev_uprsm = 0;
    check(flags === 16'h0040, "R7 resume while running", flags, 16'h0040);
    sof_en = 0;
    clear_all();

    phase = "R10";
    @(negedge clk); sof_en = 1;
    repeat (TICKS - 1) @(negedge clk);
    check(flags[2] === 1'b0 && frame_num === 11'd0, "R10 before frame", frame_num, 0);
    @(negedge clk);
    check(flags[2] === 1'b1 && frame_num === 11'd1, "R10 first frame", frame_num, 1);
    repeat (2046 * TICKS) @(negedge clk);
    check(frame_num === 11'd2047, "R10 frame 2047", frame_num, 2047);
    repeat (TICKS) @(negedge clk);
    check(frame_num === 11'd0, "R10 wrap", frame_num, 0);
    sof_en = 0;
    repeat (12) @(negedge clk);
    check(frame_num === 11'd0, "R10 held when off", frame_num, 0);

    summary();
  end
endmodule